// File: doc/BRIEF.md
# Warp Issue Eligibility Scheduler

This block picks the warp that issues next from a fixed set of warp slots. Each slot presents its decoded next instruction: a valid bit, a stall count, two source register indices, a destination register index and a flag that marks the instruction as variable-latency (a load or a texture fetch). A warp may issue only when two things are true. Its stall counter, loaded from the stall count of the instruction it issued last, must have reached zero. Its per-warp register scoreboard must also show no pending bit on any register the instruction names.

Fixed-latency arithmetic never enters the scoreboard. Its results are made safe only by the stall count that the compiler encodes in each instruction. Variable-latency instructions set a scoreboard bit for their destination when they issue. That bit stays set until a writeback port names the same warp and register. Among the eligible warps, one is granted per cycle, in round-robin order. The grant is combinational from the current state and the presented instructions. Issue effects take hold at the next clock edge.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset every stall counter and scoreboard bit is cleared, the round-robin pointer favours warp 0, and with no valid instruction `grantValid` is low.
- R2: `grantValid` is high only when some warp is eligible, and `grantWarp` then names a warp whose `instValid` bit is high.
- R3: A warp granted with stall field S (4 bits, at bits [4w+3:4w] of `instStall`) is not granted in the S cycles that follow, and is eligible again in the cycle after those. S = 0 leaves it eligible in the very next cycle.
- R4: Issuing a variable-latency instruction (`instVarLat[w]` = 1) marks its destination pending. While a register is pending, a warp whose instruction reads it as source A or B, or writes it, is not granted.
- R5: A writeback (`wbValid`, `wbWarp`, `wbReg`) clears the named bit at the clock edge, so a warp blocked only by that bit can be granted in the next cycle.
- R6: When a variable-latency issue sets a bit and a writeback clears that same bit in the same cycle, the bit ends up pending.
- R7: The search for an eligible warp starts at the slot after the warp granted most recently and wraps around, so that the first eligible slot in that order is granted.
- R8: Fixed-latency instructions mark nothing pending. A later instruction that reads their destination is held back only by the stall count.
- R9: Scoreboard bits are kept per warp. A register pending in one warp does not block another warp that uses the same index.
- R10: A writeback that names a different warp from the one holding a pending bit leaves that bit pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| instValid | input | NUM_WARPS | Per-warp next-instruction valid |
| instStall | input | NUM_WARPS*STALL_W | Per-warp stall field, slot w at [STALL_W*w +: STALL_W] |
| instSrcA | input | NUM_WARPS*REG_W | Per-warp first source register index |
| instSrcB | input | NUM_WARPS*REG_W | Per-warp second source register index |
| instDst | input | NUM_WARPS*REG_W | Per-warp destination register index |
| instVarLat | input | NUM_WARPS | Per-warp flag: instruction has variable latency |
| wbValid | input | 1 | Writeback release strobe |
| wbWarp | input | WID_W | Warp of the released register |
| wbReg | input | REG_W | Index of the released register |
| grantValid | output | 1 | A warp issues this cycle |
| grantWarp | output | WID_W | Warp that issues this cycle |

## Verification
The directed part goes after the stall window boundary. A counter that is off by one either releases a warp one cycle early or holds it one cycle too long, and the cycle-exact expected grants catch both. It tests a writeback and a new pending mark on the same bit in the same cycle; an implementation where the clear wins would issue the dependent reader at once. It also checks that a fixed-latency producer never blocks its reader, that a pending bit in one warp stays invisible to the other warps, and that a writeback aimed at the wrong warp releases nothing. The random part mixes stall counts, small register ranges and writebacks, so that the round-robin pointer, wraparound and mixed hazards are compared every cycle against a model in the bench.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int DEF_WARPS  = 8;
  localparam int DEF_STALLW = 4;
  localparam int DEF_REGS   = 32;

  // Strobes from control to datapath for the instruction issuing this cycle
  typedef struct packed {
    logic issueEn;   // a warp is granted
    logic markBusy;  // granted instruction has variable latency
  } issueStrobe_t;
endpackage

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
  parameter int N   = 8,
  parameter int IDW = $clog2(N)
) (
  input  logic [N-1:0]   req,
  input  logic [IDW-1:0] lastIdx,
  output logic           found,
  output logic [IDW-1:0] pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int off = 1; off <= N; off++) begin
      int idx;
      idx = int'(lastIdx) + off;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = IDW'(idx);
      end
    end
  end
endmodule

// File: rtl/wis_datapath.sv
module wis_datapath
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = DEF_WARPS,
  parameter int STALL_W   = DEF_STALLW,
  parameter int NUM_REGS  = DEF_REGS,
  localparam int WID_W    = $clog2(NUM_WARPS),
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  issueStrobe_t                 strobe,
  input  logic [WID_W-1:0]             issueWarp,
  input  logic [NUM_WARPS*STALL_W-1:0] instStall,
  input  logic [NUM_WARPS*REG_W-1:0]   instSrcA,
  input  logic [NUM_WARPS*REG_W-1:0]   instSrcB,
  input  logic [NUM_WARPS*REG_W-1:0]   instDst,
  input  logic                         wbValid,
  input  logic [WID_W-1:0]             wbWarp,
  input  logic [REG_W-1:0]             wbReg,
  output logic [NUM_WARPS-1:0]         stallDone,
  output logic [NUM_WARPS-1:0]         regHazard
);
  genvar w;
  generate
    for (w = 0; w < NUM_WARPS; w++) begin : g_warp
      logic [STALL_W-1:0]  stallCnt;
      logic [NUM_REGS-1:0] busy;
      logic [NUM_REGS-1:0] setVec;
      logic [NUM_REGS-1:0] clrVec;
      logic                hitIssue;
      logic [REG_W-1:0]    srcA, srcB, dst;

      assign srcA     = instSrcA[w*REG_W +: REG_W];
      assign srcB     = instSrcB[w*REG_W +: REG_W];
      assign dst      = instDst[w*REG_W +: REG_W];
      assign hitIssue = strobe.issueEn && (issueWarp == WID_W'(w));

      // Fixed-latency masking: count down the compiler-supplied stall
      always_ff @(posedge clk) begin
        if (!rstN)
          stallCnt <= '0;
        else if (hitIssue)
          stallCnt <= instStall[w*STALL_W +: STALL_W];
        else if (stallCnt != '0)
          stallCnt <= stallCnt - 1'b1;
      end

      // Variable-latency scoreboard: set beats clear on the same bit
      always_comb begin
        setVec = '0;
        clrVec = '0;
        if (hitIssue && strobe.markBusy) setVec[dst] = 1'b1;
        if (wbValid && (wbWarp == WID_W'(w))) clrVec[wbReg] = 1'b1;
      end

      always_ff @(posedge clk) begin
        if (!rstN)
          busy <= '0;
        else
          busy <= (busy & ~clrVec) | setVec;
      end

      assign stallDone[w] = (stallCnt == '0);
      assign regHazard[w] = busy[srcA] | busy[srcB] | busy[dst];
    end
  endgenerate
endmodule

// File: rtl/wis_ctrl.sv
module wis_ctrl
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = DEF_WARPS,
  localparam int WID_W    = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_WARPS-1:0] instValid,
  input  logic [NUM_WARPS-1:0] instVarLat,
  input  logic [NUM_WARPS-1:0] stallDone,
  input  logic [NUM_WARPS-1:0] regHazard,
  output issueStrobe_t         strobe,
  output logic [WID_W-1:0]     issueWarp,
  output logic                 grantValid,
  output logic [WID_W-1:0]     grantWarp
);
  logic [NUM_WARPS-1:0] eligible;
  logic [WID_W-1:0]     lastGrant;
  logic                 found;
  logic [WID_W-1:0]     pick;

  assign eligible = instValid & stallDone & ~regHazard;

  wis_rr_pick #(.N(NUM_WARPS), .IDW(WID_W)) u_pick (
    .req    (eligible),
    .lastIdx(lastGrant),
    .found  (found),
    .pick   (pick)
  );

  always_ff @(posedge clk) begin
    if (!rstN)
      lastGrant <= WID_W'(NUM_WARPS - 1);
    else if (found)
      lastGrant <= pick;
  end

  assign grantValid      = found;
  assign grantWarp       = pick;
  assign issueWarp       = pick;
  assign strobe.issueEn  = found;
  assign strobe.markBusy = found && instVarLat[pick];
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = DEF_WARPS,
  parameter int STALL_W   = DEF_STALLW,
  parameter int NUM_REGS  = DEF_REGS,
  localparam int WID_W    = $clog2(NUM_WARPS),
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_WARPS-1:0]         instValid,
  input  logic [NUM_WARPS*STALL_W-1:0] instStall,
  input  logic [NUM_WARPS*REG_W-1:0]   instSrcA,
  input  logic [NUM_WARPS*REG_W-1:0]   instSrcB,
  input  logic [NUM_WARPS*REG_W-1:0]   instDst,
  input  logic [NUM_WARPS-1:0]         instVarLat,
  input  logic                         wbValid,
  input  logic [WID_W-1:0]             wbWarp,
  input  logic [REG_W-1:0]             wbReg,
  output logic                         grantValid,
  output logic [WID_W-1:0]             grantWarp
);
  issueStrobe_t         strobe;
  logic [WID_W-1:0]     issueWarp;
  logic [NUM_WARPS-1:0] stallDone;
  logic [NUM_WARPS-1:0] regHazard;

  wis_ctrl #(.NUM_WARPS(NUM_WARPS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .instVarLat(instVarLat),
    .stallDone (stallDone),
    .regHazard (regHazard),
    .strobe    (strobe),
    .issueWarp (issueWarp),
    .grantValid(grantValid),
    .grantWarp (grantWarp)
  );

  wis_datapath #(.NUM_WARPS(NUM_WARPS), .STALL_W(STALL_W), .NUM_REGS(NUM_REGS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .issueWarp(issueWarp),
    .instStall(instStall),
    .instSrcA (instSrcA),
    .instSrcB (instSrcB),
    .instDst  (instDst),
    .wbValid  (wbValid),
    .wbWarp   (wbWarp),
    .wbReg    (wbReg),
    .stallDone(stallDone),
    .regHazard(regHazard)
  );
endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
  parameter int NUM_WARPS = 8,
  parameter int STALL_W   = 4,
  parameter int NUM_REGS  = 32,
  localparam int WID_W    = $clog2(NUM_WARPS),
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_WARPS-1:0]         instValid,
  input logic [NUM_WARPS*STALL_W-1:0] instStall,
  input logic [NUM_WARPS*REG_W-1:0]   instSrcA,
  input logic [NUM_WARPS*REG_W-1:0]   instSrcB,
  input logic [NUM_WARPS*REG_W-1:0]   instDst,
  input logic [NUM_WARPS-1:0]         instVarLat,
  input logic                         wbValid,
  input logic [WID_W-1:0]             wbWarp,
  input logic [REG_W-1:0]             wbReg,
  input logic                         grantValid,
  input logic [WID_W-1:0]             grantWarp
);
  logic armed;
  always_ff @(posedge clk) armed <= rstN;

  logic [STALL_W-1:0] gStall;
  logic [REG_W-1:0]   gSrcA, gSrcB, gDst;
  logic               gVarLat;
  assign gStall  = instStall[grantWarp*STALL_W +: STALL_W];
  assign gSrcA   = instSrcA[grantWarp*REG_W +: REG_W];
  assign gSrcB   = instSrcB[grantWarp*REG_W +: REG_W];
  assign gDst    = instDst[grantWarp*REG_W +: REG_W];
  assign gVarLat = instVarLat[grantWarp];

  p_grant_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> instValid[grantWarp]);

  p_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (instValid == '0) |-> !grantValid);

  p_stall_mask_r3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && grantValid && gStall != '0) |=>
      !(grantValid && grantWarp == $past(grantWarp)));

  // R4 and R6: a fresh pending mark blocks the next cycle even if a writeback hits it
  p_sb_block_r4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && grantValid && gVarLat) |=>
      !(grantValid && grantWarp == $past(grantWarp) &&
        (gSrcA == $past(gDst) || gSrcB == $past(gDst) || gDst == $past(gDst))));

  always_ff @(posedge clk) begin
    if (rstN) p_grant_known_r2: assert (!grantValid || !$isunknown(grantWarp));
  end
endmodule

bind warp_issue_sched wis_checker #(
  .NUM_WARPS(NUM_WARPS), .STALL_W(STALL_W), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk(clk), .rstN(rstN), .instValid(instValid), .instStall(instStall),
  .instSrcA(instSrcA), .instSrcB(instSrcB), .instDst(instDst),
  .instVarLat(instVarLat), .wbValid(wbValid), .wbWarp(wbWarp), .wbReg(wbReg),
  .grantValid(grantValid), .grantWarp(grantWarp)
);

// File: tb/warp_issue_sched_test.sv
module warp_issue_sched_test;
  localparam int PERIOD = 10;
  localparam int W  = 8;
  localparam int SW = 4;
  localparam int NR = 32;
  localparam int WW = 3;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [W-1:0]  instValid = '0;
  logic [W*SW-1:0] instStall = '0;
  logic [W*RW-1:0] instSrcA = '0, instSrcB = '0, instDst = '0;
  logic [W-1:0]  instVarLat = '0;
  logic          wbValid = 1'b0;
  logic [WW-1:0] wbWarp = '0;
  logic [RW-1:0] wbReg = '0;
  logic          grantValid;
  logic [WW-1:0] grantWarp;

  warp_issue_sched uut (.*);

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // Bench model
  int cnt [W];
  bit busy [W][NR];
  int lastG;
  bit eV;
  int eW;

  function automatic bit elig(int w);
    int a, b, d;
    a = int'(instSrcA[w*RW +: RW]);
    b = int'(instSrcB[w*RW +: RW]);
    d = int'(instDst[w*RW +: RW]);
    return instValid[w] && cnt[w] == 0 && !busy[w][a] && !busy[w][b] && !busy[w][d];
  endfunction

  task automatic setInst(int w, bit v, int s, int a, int b, int d, bit vl);
    instValid[w] = v;
    instStall[w*SW +: SW] = SW'(s);
    instSrcA[w*RW +: RW] = RW'(a);
    instSrcB[w*RW +: RW] = RW'(b);
    instDst[w*RW +: RW]  = RW'(d);
    instVarLat[w] = vl;
  endtask

  // Check the combinational grant, update the model for the coming edge, move to next negedge
  task automatic cyc(string tag);
    eV = 0; eW = 0;
    #1;
    for (int off = 1; off <= W; off++) begin
      int idx;
      idx = (lastG + off) % W;
      if (!eV && elig(idx)) begin eV = 1; eW = idx; end
    end
    checks++;
    if (grantValid !== eV || (eV && int'(grantWarp) != eW)) begin
      errors++;
      $display("FAIL %s grantValid=%0b grantWarp=%0d expected valid=%0b warp=%0d",
               tag, grantValid, grantWarp, eV, eW);
    end
    for (int w = 0; w < W; w++) begin
      if (eV && eW == w) cnt[w] = int'(instStall[w*SW +: SW]);
      else if (cnt[w] > 0) cnt[w]--;
    end
    if (wbValid) busy[wbWarp][wbReg] = 0;
    if (eV && instVarLat[eW]) busy[eW][instDst[eW*RW +: RW]] = 1;
    if (eV) lastG = eW;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int w = 0; w < W; w++) begin
      cnt[w] = 0;
      for (int r = 0; r < NR; r++) busy[w][r] = 0;
    end
    lastG = W - 1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, nothing valid
    cyc("R1");

    // R7 and R1: all warps ready, grants walk 0..7 starting at warp 0
    for (int w = 0; w < W; w++) setInst(w, 1, 0, 1, 2, 3, 0);
    for (int i = 0; i < W + 2; i++) cyc("R7");
    for (int w = 0; w < W; w++) setInst(w, 0, 0, 0, 0, 0, 0);
    cyc("R2");

    // R3: stall window of three cycles on warp 2, then zero stall
    setInst(2, 1, 3, 1, 2, 3, 0);
    for (int i = 0; i < 6; i++) cyc("R3");
    setInst(2, 1, 0, 1, 2, 3, 0);
    for (int i = 0; i < 3; i++) cyc("R3");
    setInst(2, 0, 0, 0, 0, 0, 0);

    // R4/R5: warp 1 load to r5, reader blocked until writeback
    setInst(1, 1, 0, 0, 0, 5, 1);
    cyc("R4");
    setInst(1, 1, 0, 5, 0, 9, 0);
    cyc("R4"); cyc("R4");
    wbValid = 1; wbWarp = 1; wbReg = 5;
    cyc("R5");
    wbValid = 0;
    cyc("R5");

    // R6: new mark on r6 and a writeback of r6 in the same cycle
    setInst(1, 1, 0, 0, 0, 6, 1);
    wbValid = 1; wbWarp = 1; wbReg = 6;
    cyc("R6");
    wbValid = 0;
    setInst(1, 1, 0, 0, 6, 10, 0);
    cyc("R6"); cyc("R6");
    wbValid = 1;
    cyc("R5");
    wbValid = 0;
    cyc("R5");
    setInst(1, 0, 0, 0, 0, 0, 0);

    // R8: fixed-latency producer does not block its reader
    setInst(3, 1, 0, 0, 0, 6, 0);
    cyc("R8");
    setInst(3, 1, 0, 6, 6, 11, 0);
    cyc("R8");
    setInst(3, 0, 0, 0, 0, 0, 0);

    // R9: pending r7 in warp 4 does not block warp 5
    setInst(4, 1, 0, 0, 0, 7, 1);
    cyc("R9");
    setInst(4, 0, 0, 0, 0, 0, 0);
    setInst(5, 1, 0, 7, 7, 7, 0);
    cyc("R9");
    setInst(5, 0, 0, 0, 0, 0, 0);

    // R10: writeback to the wrong warp leaves warp 4 blocked
    setInst(4, 1, 0, 7, 0, 12, 0);
    wbValid = 1; wbWarp = 5; wbReg = 7;
    cyc("R10");
    wbValid = 0;
    cyc("R10");
    wbValid = 1; wbWarp = 4; wbReg = 7;
    cyc("R5");
    wbValid = 0;
    cyc("R5");

    // Random mix
    for (int w = 0; w < W; w++)
      setInst(w, 1, $urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 7),
              $urandom_range(0, 7), ($urandom_range(0, 9) < 3));
    for (int i = 0; i < 3000; i++) begin
      wbValid = ($urandom_range(0, 9) < 4);
      wbWarp  = WW'($urandom_range(0, W - 1));
      wbReg   = RW'($urandom_range(0, 7));
      cyc("R7");
      if (eV)
        setInst(eW, ($urandom_range(0, 9) < 8), $urandom_range(0, 3), $urandom_range(0, 7),
                $urandom_range(0, 7), $urandom_range(0, 7), ($urandom_range(0, 9) < 3));
      if ($urandom_range(0, 9) == 0) begin
        int w;
        w = $urandom_range(0, W - 1);
        instValid[w] = 1'b1;
      end
    end
    finishRun();
  end
endmodule